// File: doc/BRIEF.md
# PWM Fault Guard

This block sits between a three-phase PWM generator and the things that can stop it. It has three trip sources. The first is an active-low external trip line, which is asynchronous and is synchronised inside the block. The second is an overcurrent flag from a current-sense comparator. The third is a software trip bit that is set through a small register bus. When any source trips, the block forces every PWM output low and freezes the generator's timing. It also records whether the last shutdown came from software or from hardware.

The same register bus holds the period register and one duty register for each channel. After a shutdown, restart is gated by three conditions:

- The external line must be high again.
- The overcurrent flag must be clear.
- The period register and every duty register must have been written since the last trip.

Once all three hold, the generator's timing is released. The outputs stay off until the next rising edge of the PWM sync pulse. That edge loads the newly written values into the active registers and enables the outputs.

Top module: `pwm_fault_guard`

## Requirements
- R1: After reset the block is shut down. `shutdown`=1, `pwm_run`=0, `pwm_out`=0, all shadow and active registers are 0, and the trip-source bit is 0.
- R2: A falling edge of the combined hardware trip level (`trip_n_async` synchronised, AND NOT `oc_below`) triggers a shutdown. `trip_n_async` passes two synchroniser flops, so a low level set before edge k shows `shutdown`=1 after edge k+2.
- R3: `oc_below`=1 while the synchronised line is high triggers a shutdown on the next clock edge.
- R4: A write to address 4 with `bus_wdata[0]`=1 triggers a shutdown on the next edge. A write to address 4 with bit 0 = 0 has no effect.
- R5: A read returns its data in `bus_rdata` one cycle after `bus_rd`, and `bus_rdata` is 0 in cycles with no read. A read of address 4 returns bit 0 = 1 if the last shutdown came from software and 0 if it came from hardware. That read clears the bit.
- R6: If a software trip write and a read of address 4 happen in the same cycle, the write wins and the bit stays 1.
- R7: The block stays shut down while the synchronised trip line is low or `oc_below` is 1.
- R8: The block leaves shutdown only after addresses 0 (period), 1, 2 and 3 (duty of channels A, B, C) have each been written since the most recent trip. Any trip cancels earlier writes.
- R9: When the R7 and R8 conditions hold, the next edge moves the block to an armed state: `pwm_run`=1, `shutdown`=0, `pwm_out` still 0. The first rising edge of `pwm_sync` then loads the active registers and makes `pwm_out` follow `pwm_in`.
- R10: While shut down, `pwm_out` is 0 and sync edges do not change the active registers.
- R11: While running, every rising edge of `pwm_sync` copies the shadow registers into `period_act` and `duty_act`. Channel A sits in bits [15:0], B in [31:16] and C in [47:32].
- R12: Reads of addresses 0–3 return the shadow registers. Reads of addresses 5–7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trip_n_async | input | 1 | External trip line, active low, asynchronous |
| oc_below | input | 1 | Current-sense comparator flag; 1 = sensed voltage below threshold |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, one cycle after the read strobe |
| pwm_sync | input | 1 | Sync pulse from the PWM timer |
| pwm_in | input | 6 | Raw PWM levels from the generator |
| pwm_out | output | 6 | Gated PWM levels |
| pwm_run | output | 1 | Timer enable; 0 freezes PWM timing |
| shutdown | output | 1 | 1 while shut down |
| period_act | output | 16 | Active period value |
| duty_act | output | 48 | Active duty values, channel A in the low bits |

## Verification
The bench attacks the following corner cases:

- **Software trip written and the trip source read in the same cycle.** A design where the read wins would report hardware as the source of the next shutdown.
- **A trip that is still asserted while all four registers are rewritten.** A design that tests only the write flags would restart into an active fault.
- **A second trip that lands while the block is armed.** Without clearing the write flags, the block would restart on stale values.
- **Sync edges during shutdown.** A design that latches on those edges would load half-programmed duties before the restart.

The bench also measures the two-flop delay on the external line. The trip must be neither early nor late by a cycle.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

  typedef enum logic [1:0] {
    ST_HALT  = 2'd0,
    ST_ARMED = 2'd1,
    ST_LIVE  = 2'd2
  } guard_state_e;

  // Healthy when the external line is high and no overcurrent is flagged.
  function automatic logic line_healthy(input logic trip_n_sync, input logic oc_flag);
    return trip_n_sync & ~oc_flag;
  endfunction

  // High-to-low transition of a level.
  function automatic logic went_low(input logic was, input logic now);
    return was & ~now;
  endfunction

  // Software trip: write to the trip slot with bit 0 set.
  function automatic logic sw_trip_hit(input logic wr, input logic addr_match, input logic bit0);
    return wr & addr_match & bit0;
  endfunction

endpackage

// File: rtl/pfg_trip_front.sv
module pfg_trip_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_n_async,
  input  logic oc_below,
  output logic line_ok,
  output logic trip_ev
);
  import pfg_pkg::*;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   ok_prev_q;
  logic                   trip_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], trip_n_async};
  end

  assign trip_n_s = sync_q[SYNC_STAGES-1];
  assign line_ok  = line_healthy(trip_n_s, oc_below);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ok_prev_q <= 1'b1;
    else        ok_prev_q <= line_ok;
  end

  assign trip_ev = went_low(ok_prev_q, line_ok);

endmodule

// File: rtl/pfg_regfile.sv
module pfg_regfile #(
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 16,
  parameter int N_SLOTS = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             bus_wr,
  input  logic                             bus_rd,
  input  logic [ADDR_W-1:0]                bus_addr,
  input  logic [DATA_W-1:0]                bus_wdata,
  input  logic                             hw_ev,
  output logic                             sw_ev,
  output logic                             src_bit,
  output logic                             all_written,
  output logic [N_SLOTS-1:0][DATA_W-1:0]   slot_q,
  output logic [DATA_W-1:0]                bus_rdata
);
  import pfg_pkg::*;

  localparam int SW_SLOT = N_SLOTS;

  logic               shut_ev;
  logic               sw_addr;
  logic               sw_rd;
  logic [N_SLOTS-1:0] wr_hit;
  logic [N_SLOTS-1:0] flag_q;
  logic [DATA_W-1:0]  rd_val;

  assign sw_addr = (bus_addr == ADDR_W'(SW_SLOT));
  assign sw_ev   = sw_trip_hit(bus_wr, sw_addr, bus_wdata[0]);
  assign shut_ev = sw_ev | hw_ev;
  assign sw_rd   = bus_rd & sw_addr;

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
    logic [DATA_W-1:0] val_q;
    logic              seen_q;

    assign wr_hit[g] = bus_wr & (bus_addr == ADDR_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q  <= '0;
        seen_q <= 1'b0;
      end else begin
        if (wr_hit[g]) val_q <= bus_wdata;
        if (shut_ev)        seen_q <= 1'b0;
        else if (wr_hit[g]) seen_q <= 1'b1;
      end
    end

    assign slot_q[g] = val_q;
    assign flag_q[g] = seen_q;
  end

  assign all_written = &flag_q;

  // Source bit: a software write wins over both a hardware trip and a read.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     src_bit <= 1'b0;
    else if (sw_ev) src_bit <= 1'b1;
    else if (hw_ev) src_bit <= 1'b0;
    else if (sw_rd) src_bit <= 1'b0;
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < N_SLOTS; i++) begin
      if (bus_addr == ADDR_W'(i)) rd_val = slot_q[i];
    end
    if (sw_addr) rd_val = {{(DATA_W-1){1'b0}}, src_bit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
    else             bus_rdata <= '0;
  end

endmodule

// File: rtl/pfg_sequencer.sv
module pfg_sequencer #(
  parameter int DATA_W  = 16,
  parameter int N_SLOTS = 4,
  parameter int N_PWM   = 6
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           shut_ev,
  input  logic                           line_ok,
  input  logic                           all_written,
  input  logic                           pwm_sync,
  input  logic [N_SLOTS-1:0][DATA_W-1:0] slot_q,
  input  logic [N_PWM-1:0]               pwm_in,
  output logic [N_SLOTS-1:0][DATA_W-1:0] act_q,
  output logic [N_PWM-1:0]               pwm_out,
  output logic                           sync_rise,
  output logic                           halted,
  output logic                           armed,
  output logic                           live
);
  import pfg_pkg::*;

  guard_state_e st_q, st_d;
  logic         sync_prev_q;
  logic         latch_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_prev_q <= 1'b0;
    else        sync_prev_q <= pwm_sync;
  end

  assign sync_rise = pwm_sync & ~sync_prev_q;

  always_comb begin
    st_d = st_q;
    if (shut_ev) begin
      st_d = ST_HALT;
    end else begin
      case (st_q)
        ST_HALT:  if (line_ok && all_written) st_d = ST_ARMED;
        ST_ARMED: if (sync_rise)              st_d = ST_LIVE;
        default:                              st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_HALT;
    else        st_q <= st_d;
  end

  assign latch_go = sync_rise & (st_q != ST_HALT) & ~shut_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        act_q <= '0;
    else if (latch_go) act_q <= slot_q;
  end

  assign halted  = (st_q == ST_HALT);
  assign armed   = (st_q == ST_ARMED);
  assign live    = (st_q == ST_LIVE);
  assign pwm_out = live ? pwm_in : '0;

endmodule

// File: rtl/pwm_fault_guard.sv
module pwm_fault_guard #(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 3,
  parameter int N_CH        = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   trip_n_async,
  input  logic                   oc_below,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [DATA_W-1:0]      bus_wdata,
  output logic [DATA_W-1:0]      bus_rdata,
  input  logic                   pwm_sync,
  input  logic [2*N_CH-1:0]      pwm_in,
  output logic [2*N_CH-1:0]      pwm_out,
  output logic                   pwm_run,
  output logic                   shutdown,
  output logic [DATA_W-1:0]      period_act,
  output logic [N_CH*DATA_W-1:0] duty_act
);
  localparam int N_SLOTS = N_CH + 1;
  localparam int N_PWM   = 2 * N_CH;

  // Internal events, named so the checker can observe them.
  logic                           line_ok;
  logic                           trip_ev;
  logic                           sw_ev;
  logic                           shut_ev;
  logic                           src_bit;
  logic                           all_written;
  logic                           sync_rise;
  logic                           halted;
  logic                           armed;
  logic                           live;
  logic [N_SLOTS-1:0][DATA_W-1:0] slot_q;
  logic [N_SLOTS-1:0][DATA_W-1:0] act_q;

  pfg_trip_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk          (clk),
    .rst_n        (rst_n),
    .trip_n_async (trip_n_async),
    .oc_below     (oc_below),
    .line_ok      (line_ok),
    .trip_ev      (trip_ev)
  );

  pfg_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_SLOTS(N_SLOTS)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .hw_ev       (trip_ev),
    .sw_ev       (sw_ev),
    .src_bit     (src_bit),
    .all_written (all_written),
    .slot_q      (slot_q),
    .bus_rdata   (bus_rdata)
  );

  assign shut_ev = trip_ev | sw_ev;

  pfg_sequencer #(.DATA_W(DATA_W), .N_SLOTS(N_SLOTS), .N_PWM(N_PWM)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .shut_ev     (shut_ev),
    .line_ok     (line_ok),
    .all_written (all_written),
    .pwm_sync    (pwm_sync),
    .slot_q      (slot_q),
    .pwm_in      (pwm_in),
    .act_q       (act_q),
    .pwm_out     (pwm_out),
    .sync_rise   (sync_rise),
    .halted      (halted),
    .armed       (armed),
    .live        (live)
  );

  assign shutdown   = halted;
  assign pwm_run    = ~halted;
  assign period_act = act_q[0];
  assign duty_act   = act_q[N_SLOTS-1:1];

endmodule

// File: rtl/pfg_checker.sv
module pfg_checker #(
  parameter int N_PWM = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trip_ev,
  input logic             sw_ev,
  input logic             shut_ev,
  input logic             line_ok,
  input logic             all_written,
  input logic             sync_rise,
  input logic             shutdown,
  input logic             armed,
  input logic             live,
  input logic             src_bit,
  input logic [N_PWM-1:0] pwm_out
);

  // R10
  halt_outputs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |-> (pwm_out == '0));

  // R2
  hw_trip_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trip_ev |=> shutdown);

  // R4
  sw_trip_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_ev |=> shutdown);

  // R6
  sw_write_sets_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_ev |=> src_bit);

  // R7
  no_exit_while_faulted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shutdown && !line_ok) |=> shutdown);

  // R8
  no_exit_unwritten_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shutdown && !all_written) |=> shutdown);

  // R9
  armed_waits_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !sync_rise && !shut_ev) |=> armed);

  // R9
  arm_to_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && sync_rise && !shut_ev) |=> live);

  // R9
  one_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({shutdown, armed, live}));

endmodule

bind pwm_fault_guard pfg_checker #(.N_PWM(2*N_CH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .trip_ev     (trip_ev),
  .sw_ev       (sw_ev),
  .shut_ev     (shut_ev),
  .line_ok     (line_ok),
  .all_written (all_written),
  .sync_rise   (sync_rise),
  .shutdown    (shutdown),
  .armed       (armed),
  .live        (live),
  .src_bit     (src_bit),
  .pwm_out     (pwm_out)
);

// File: tb/sim_pwm_fault_guard.sv
module sim_pwm_fault_guard;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trip_n_async = 1'b1;
  logic        oc_below = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        pwm_sync = 1'b0;
  logic [5:0]  pwm_in = '0;
  logic [5:0]  pwm_out;
  logic        pwm_run;
  logic        shutdown;
  logic [15:0] period_act;
  logic [47:0] duty_act;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit go = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  pwm_fault_guard u0 (
    .clk(clk), .rst_n(rst_n), .trip_n_async(trip_n_async), .oc_below(oc_below),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pwm_sync(pwm_sync), .pwm_in(pwm_in), .pwm_out(pwm_out),
    .pwm_run(pwm_run), .shutdown(shutdown), .period_act(period_act), .duty_act(duty_act)
  );

  // Behavioural reference: 0 = halted, 1 = armed, 2 = running.
  int m_state, m_src, m_rdata;
  int m_slot[4];
  int m_act[4];
  bit m_flag[4];
  bit m_s1, m_s2, m_prevok, m_syncp;

  always @(posedge clk) begin
    pwm_in <= pwm_in + 6'd5;
    if (!rst_n) begin
      m_state = 0; m_src = 0; m_rdata = 0;
      m_s1 = 1; m_s2 = 1; m_prevok = 1; m_syncp = 0;
      foreach (m_slot[i]) begin m_slot[i] = 0; m_act[i] = 0; m_flag[i] = 0; end
    end else begin : upd
      int a, ns;
      bit okn, hw, sw, ev, rise, allw;
      a    = int'(bus_addr);
      okn  = m_s2 && !oc_below;
      hw   = m_prevok && !okn;
      sw   = bus_wr && a == 4 && bus_wdata[0];
      ev   = hw || sw;
      rise = pwm_sync && !m_syncp;
      allw = m_flag[0] && m_flag[1] && m_flag[2] && m_flag[3];
      if (bus_rd) m_rdata = (a < 4) ? m_slot[a] : (a == 4) ? m_src : 0;
      else        m_rdata = 0;
      if (ev)                            ns = 0;
      else if (m_state == 0 && okn && allw) ns = 1;
      else if (m_state == 1 && rise)     ns = 2;
      else                               ns = m_state;
      if (rise && m_state != 0 && !ev) foreach (m_act[i]) m_act[i] = m_slot[i];
      if (sw)                     m_src = 1;
      else if (hw)                m_src = 0;
      else if (bus_rd && a == 4)  m_src = 0;
      if (bus_wr && a < 4) m_slot[a] = int'(bus_wdata);
      if (ev) foreach (m_flag[i]) m_flag[i] = 0;
      else if (bus_wr && a < 4) m_flag[a] = 1;
      m_state = ns;
      m_s2 = m_s1; m_s1 = trip_n_async; m_prevok = okn; m_syncp = pwm_sync;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Every-cycle comparison against the reference.
  always @(negedge clk) begin
    if (go && rst_n) begin
      chk(shutdown == (m_state == 0), cur_req, shutdown, m_state == 0);
      chk(pwm_run == (m_state != 0), cur_req, pwm_run, m_state != 0);
      chk(pwm_out == ((m_state == 2) ? pwm_in : 6'd0), cur_req, pwm_out,
          (m_state == 2) ? pwm_in : 0);
      chk(bus_rdata == 16'(m_rdata), cur_req, bus_rdata, m_rdata);
      chk(period_act == 16'(m_act[0]), cur_req, period_act, m_act[0]);
      for (int i = 0; i < 3; i++)
        chk(duty_act[i*16 +: 16] == 16'(m_act[i+1]), cur_req, duty_act[i*16 +: 16], m_act[i+1]);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr(input int a, input int d);
    bus_wr = 1; bus_addr = 3'(a); bus_wdata = 16'(d);
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input int a, output int v);
    bus_rd = 1; bus_addr = 3'(a);
    @(negedge clk);
    v = int'(bus_rdata);
    bus_rd = 0;
  endtask

  task automatic sync_pulse();
    pwm_sync = 1;
    @(negedge clk);
    pwm_sync = 0;
    @(negedge clk);
  endtask

  task automatic program_all(input int p, input int a, input int b, input int c);
    wr(0, p); wr(1, a); wr(2, b); wr(3, c);
  endtask

  initial begin : main
    int v;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(shutdown == 1, "R1", shutdown, 1);
    chk(pwm_run == 0, "R1", pwm_run, 0);
    chk(pwm_out == 0, "R1", pwm_out, 0);
    rst_n = 1;
    go = 1;
    @(negedge clk);
    rd(4, v); chk(v == 0, "R1", v, 0);

    // R8: three of four writes keep it halted
    cur_req = "R8";
    wr(0, 100); wr(1, 10); wr(2, 20);
    @(negedge clk);
    chk(shutdown == 1, "R8", shutdown, 1);
    wr(3, 30);
    @(negedge clk);
    // R9 armed: running timer, outputs off
    cur_req = "R9";
    chk(pwm_run == 1 && shutdown == 0, "R9", pwm_run, 1);
    chk(pwm_out == 0, "R9", pwm_out, 0);
    repeat (3) @(negedge clk);
    sync_pulse();
    chk(duty_act[15:0] == 10 && period_act == 100, "R9", duty_act[15:0], 10);
    chk(pwm_out == pwm_in, "R9", pwm_out, pwm_in);

    // R11 running update on sync, R12 readback
    cur_req = "R11";
    wr(1, 55); wr(3, 77);
    chk(duty_act[15:0] == 10, "R11", duty_act[15:0], 10);
    sync_pulse();
    chk(duty_act[15:0] == 55 && duty_act[47:32] == 77, "R11", duty_act[15:0], 55);
    cur_req = "R12";
    rd(1, v); chk(v == 55, "R12", v, 55);
    rd(6, v); chk(v == 0, "R12", v, 0);

    // R4 software trip
    cur_req = "R4";
    wr(4, 0);
    chk(shutdown == 0, "R4", shutdown, 0);
    wr(4, 1);
    chk(shutdown == 1, "R4", shutdown, 1);
    // R5 source read and clear
    cur_req = "R5";
    rd(4, v); chk(v == 1, "R5", v, 1);
    rd(4, v); chk(v == 0, "R5", v, 0);

    // R10 sync while halted leaves active regs
    cur_req = "R10";
    wr(1, 99);
    sync_pulse();
    chk(duty_act[15:0] == 55, "R10", duty_act[15:0], 55);
    chk(pwm_out == 0, "R10", pwm_out, 0);

    // restart
    cur_req = "R9";
    program_all(200, 11, 22, 33);
    @(negedge clk);
    sync_pulse();
    chk(duty_act[31:16] == 22, "R9", duty_act[31:16], 22);

    // R2 external trip through two sync flops
    cur_req = "R2";
    trip_n_async = 0;
    @(negedge clk);
    @(negedge clk);
    chk(shutdown == 0, "R2", shutdown, 0);
    @(negedge clk);
    chk(shutdown == 1, "R2", shutdown, 1);
    cur_req = "R5";
    rd(4, v); chk(v == 0, "R5", v, 0);
    // R7 rewrite while tripped
    cur_req = "R7";
    program_all(300, 1, 2, 3);
    repeat (3) @(negedge clk);
    chk(shutdown == 1, "R7", shutdown, 1);
    trip_n_async = 1;
    repeat (4) @(negedge clk);
    chk(pwm_run == 1, "R7", pwm_run, 1);
    sync_pulse();

    // R3 overcurrent
    cur_req = "R3";
    oc_below = 1;
    @(negedge clk);
    chk(shutdown == 1, "R3", shutdown, 1);
    cur_req = "R7";
    program_all(400, 4, 5, 6);
    @(negedge clk);
    chk(shutdown == 1, "R7", shutdown, 1);
    oc_below = 0;
    @(negedge clk);
    chk(pwm_run == 1, "R7", pwm_run, 1);

    // R8 trip while armed cancels writes
    cur_req = "R8";
    wr(4, 1);
    wr(0, 1); wr(1, 2); wr(2, 3);
    repeat (2) @(negedge clk);
    chk(shutdown == 1, "R8", shutdown, 1);

    // R6 simultaneous write and read of the trip slot
    cur_req = "R6";
    bus_wr = 1; bus_rd = 1; bus_addr = 3'd4; bus_wdata = 16'd1;
    @(negedge clk);
    chk(bus_rdata == 1, "R6", bus_rdata, 1);
    bus_wr = 0; bus_rd = 0;
    rd(4, v); chk(v == 1, "R6", v, 1);
    rd(4, v); chk(v == 0, "R6", v, 0);

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule